// File: doc/BRIEF.md
# Receive Endpoint Control and Status Registers

This block holds the receive-side control and status state for the four endpoints of a full-speed USB device controller. A processor accesses it through a small register port. An endpoint index and a register address pick one byte. A write strobe with write data updates that byte, and the read data shows it in the same cycle. Each endpoint has two registers.

- The configuration byte enables reception on the endpoint and, on the one endpoint that supports it, selects isochronous transfer type.
- The status byte carries the following state:
  - the expected OUT data-toggle value;
  - a flag marking SETUP reception;
  - a start/end pair that tracks a SETUP packet overwriting the receive FIFO;
  - a sticky flag for a FIFO access collision.

The USB protocol engine reports events on one endpoint at a time: an acknowledged OUT transaction, a SETUP token, an acknowledged SETUP transaction and the arrival of host data. Together with the processor's last-byte FIFO read strobe, these events drive the hardware updates. The block returns to the engine whether the addressed endpoint accepts traffic, and gives per-endpoint enable, isochronous and toggle outputs. A system reset (asynchronous, active low) and a USB bus reset (synchronous) both restore the reset state.

Top module: `usbrx_ep_regs`

## Requirements
- R1: After either reset, every status byte reads 0x00. Endpoint 0's configuration byte reads 0x01 and the other endpoints' read 0x00. `ep_rx_en` is 4'b0001.
- R2: Address 0 is the configuration byte: bit 0 is receive enable and bit 1 is isochronous type. Address 1 is the status byte: bit 7 is the toggle, bit 6 is setup-received, bit 5 is start-overwrite, bit 4 is end-overwrite, bit 3 is the toggle unlock, bit 2 is the collision flag, and bits 1:0 always read 0. Addresses 2 and 3 read 0x00 and ignore writes.
- R3: An acknowledged OUT transaction on an enabled endpoint inverts that endpoint's toggle bit.
- R4: A status write changes the toggle to written bit 7 only when written bit 3 is 1. Otherwise the toggle is kept. Bit 3 always reads 0.
- R5: An acknowledged SETUP on an enabled control endpoint (endpoint 0) sets setup-received and forces the toggle to 1. Writing 0 to bit 6 clears setup-received, and writing 1 keeps it.
- R6: A SETUP token on an enabled control endpoint sets start-overwrite, which processor writes cannot change. On non-control endpoints, SETUP events change no status bit.
- R7: An acknowledged SETUP on a control endpoint sets end-overwrite and clears start-overwrite. Writing 0 to bit 4 clears end-overwrite, and writing 1 keeps it.
- R8: When the processor reads the last FIFO byte of endpoint `cpu_ep` in the same cycle that host data arrives for the same endpoint, that endpoint's collision flag sets. It stays set until a status write puts 0 in bit 2. A read and an arrival on different endpoints set nothing.
- R9: On a disabled endpoint, every protocol event is ignored, and `ev_accept` is 0 when `ev_ep` selects that endpoint.
- R10: Only endpoint 3 stores the isochronous bit. On other endpoints, config bit 1 reads 0 and `ep_rx_iso` stays 0.
- R11: When a hardware set and a firmware clear or toggle write hit the same bit in the same cycle, the hardware result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| usb_rst | input | 1 | Synchronous USB bus reset, active high |
| cpu_ep | input | 2 | Endpoint index for register access and last-byte read |
| cpu_addr | input | 2 | Register address within the endpoint |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the selected register |
| cpu_last_rd | input | 1 | Processor reads the last FIFO byte of `cpu_ep` |
| ev_ep | input | 2 | Endpoint of the protocol event |
| ev_out_ack | input | 1 | OUT transaction acknowledged |
| ev_setup_tok | input | 1 | SETUP token received |
| ev_setup_ack | input | 1 | SETUP transaction acknowledged |
| ev_data_arrive | input | 1 | Host data arriving |
| ev_accept | output | 1 | Endpoint `ev_ep` has reception enabled |
| ep_rx_en | output | 4 | Per-endpoint receive enable |
| ep_rx_iso | output | 4 | Per-endpoint isochronous type |
| ep_rx_seq | output | 4 | Per-endpoint expected data toggle |

## Verification
The embedded assertions check the following on every cycle:
- the SETUP acknowledgement forces the toggle and the flags;
- an OUT acknowledgement inverts the toggle;
- the toggle holds on writes that do not unlock it;
- processor writes leave start-overwrite alone;
- the collision flag is sticky;
- a disabled endpoint's status stays frozen;
- the reserved read bits are zero.

Only the bench's scenarios show the following:
- the exact reset bytes after each kind of reset;
- the register addressing;
- that SETUP events on non-control endpoints are dropped;
- that a collision needs the same endpoint on both sides;
- the same-cycle priority of hardware updates over firmware writes.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;

  // configuration byte fields
  localparam int CFG_EN  = 0;
  localparam int CFG_ISO = 1;

  // status byte fields (firmware decodes these positions)
  localparam int ST_SEQ    = 7;
  localparam int ST_SETUP  = 6;
  localparam int ST_STOVW  = 5;
  localparam int ST_EDOVW  = 4;
  localparam int ST_UNLOCK = 3;
  localparam int ST_COLL   = 2;

  typedef struct packed {
    logic seq;
    logic setup;
    logic st_ovw;
    logic ed_ovw;
    logic coll;
  } rx_stat_t;

  // toggle update: setup ack forces 1, OUT ack inverts, unlocked write loads
  function automatic logic seq_next(input logic cur, input logic setup_ack,
                                    input logic out_ack, input logic unlock,
                                    input logic wval);
    if (setup_ack)   return 1'b1;
    else if (out_ack) return ~cur;
    else if (unlock)  return wval;
    else              return cur;
  endfunction

  // sticky flag: hardware set takes priority over firmware clear
  function automatic logic flag_next(input logic cur, input logic hw_set,
                                     input logic fw_clr);
    if (hw_set)      return 1'b1;
    else if (fw_clr) return 1'b0;
    else             return cur;
  endfunction

  function automatic logic [REG_W-1:0] stat_to_byte(input rx_stat_t s);
    logic [REG_W-1:0] b;
    b = '0;
    b[ST_SEQ]   = s.seq;
    b[ST_SETUP] = s.setup;
    b[ST_STOVW] = s.st_ovw;
    b[ST_EDOVW] = s.ed_ovw;
    b[ST_COLL]  = s.coll;
    return b;
  endfunction
endpackage

// File: rtl/usbrx_ep_slice.sv
module usbrx_ep_slice
  import usbrx_pkg::*;
#(
  parameter bit IS_CTRL = 1'b0,
  parameter bit ISO_CAP = 1'b0,
  parameter bit EN_RST  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usb_rst,
  input  logic             wr_cfg_i,
  input  logic             wr_stat_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             out_ack_i,
  input  logic             setup_tok_i,
  input  logic             setup_ack_i,
  input  logic             conflict_i,
  output logic             en_o,
  output logic             iso_o,
  output logic             seq_o,
  output logic [REG_W-1:0] cfg_byte_o,
  output logic [REG_W-1:0] stat_byte_o
);
  logic     en_q, iso_q;
  rx_stat_t st_q, st_d;

  // named internal events
  logic hw_out_ack, hw_setup_tok, hw_setup_ack, hw_conflict;
  logic fw_unlock, fw_clr_setup, fw_clr_ed, fw_clr_coll;

  assign hw_out_ack   = out_ack_i & en_q;
  assign hw_setup_tok = setup_tok_i & en_q & IS_CTRL;
  assign hw_setup_ack = setup_ack_i & en_q & IS_CTRL;
  assign hw_conflict  = conflict_i & en_q;

  assign fw_unlock    = wr_stat_i &  wdata_i[ST_UNLOCK];
  assign fw_clr_setup = wr_stat_i & ~wdata_i[ST_SETUP];
  assign fw_clr_ed    = wr_stat_i & ~wdata_i[ST_EDOVW];
  assign fw_clr_coll  = wr_stat_i & ~wdata_i[ST_COLL];

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[REG_W-1:CFG_ISO+1], wdata_i[ST_STOVW]};

  always_comb begin
    st_d.seq    = seq_next(st_q.seq, hw_setup_ack, hw_out_ack, fw_unlock,
                           wdata_i[ST_SEQ]);
    st_d.setup  = flag_next(st_q.setup, hw_setup_ack, fw_clr_setup);
    st_d.ed_ovw = flag_next(st_q.ed_ovw, hw_setup_ack, fw_clr_ed);
    st_d.coll   = flag_next(st_q.coll, hw_conflict, fw_clr_coll);
    if (hw_setup_ack)      st_d.st_ovw = 1'b0;
    else if (hw_setup_tok) st_d.st_ovw = 1'b1;
    else                   st_d.st_ovw = st_q.st_ovw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      en_q  <= EN_RST;
      iso_q <= 1'b0;
    end else if (usb_rst) begin
      st_q  <= '0;
      en_q  <= EN_RST;
      iso_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (wr_cfg_i) begin
        en_q  <= wdata_i[CFG_EN];
        iso_q <= ISO_CAP & wdata_i[CFG_ISO];
      end
    end
  end

  assign en_o  = en_q;
  assign iso_o = iso_q;
  assign seq_o = st_q.seq;

  always_comb begin
    cfg_byte_o          = '0;
    cfg_byte_o[CFG_EN]  = en_q;
    cfg_byte_o[CFG_ISO] = iso_q;
  end
  assign stat_byte_o = stat_to_byte(st_q);

  assert_out_ack_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n || usb_rst)
    hw_out_ack && !hw_setup_ack |=> st_q.seq != $past(st_q.seq));
  assert_seq_locked_R4: assert property (@(posedge clk) disable iff (!rst_n || usb_rst)
    wr_stat_i && !wdata_i[ST_UNLOCK] && !out_ack_i && !setup_ack_i |=> $stable(st_q.seq));
  assert_setup_ack_sets_R5: assert property (@(posedge clk) disable iff (!rst_n || usb_rst)
    hw_setup_ack |=> st_q.seq && st_q.setup);
  assert_stovw_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n || usb_rst)
    wr_stat_i && !setup_tok_i && !setup_ack_i |=> $stable(st_q.st_ovw));
  assert_edovw_clears_stovw_R7: assert property (@(posedge clk) disable iff (!rst_n || usb_rst)
    hw_setup_ack |=> st_q.ed_ovw && !st_q.st_ovw);
  assert_coll_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n || usb_rst)
    st_q.coll && !wr_stat_i |=> st_q.coll);
  assert_disabled_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n || usb_rst)
    !en_q && !wr_stat_i && !wr_cfg_i |=> $stable(stat_byte_o));
  assert_hw_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n || usb_rst)
    hw_conflict && wr_stat_i |=> st_q.coll);
endmodule

// File: rtl/usbrx_rd_mux.sv
module usbrx_rd_mux
  import usbrx_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EP_W  = $clog2(NUM_EP)
) (
  input  logic [EP_W-1:0]              sel_ep,
  input  logic [ADDR_W-1:0]            sel_addr,
  input  logic [NUM_EP-1:0][REG_W-1:0] cfg_bytes,
  input  logic [NUM_EP-1:0][REG_W-1:0] stat_bytes,
  output logic [REG_W-1:0]             rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (sel_ep == EP_W'(i)) begin
        if (sel_addr == ADDR_CFG)       rdata = cfg_bytes[i];
        else if (sel_addr == ADDR_STAT) rdata = stat_bytes[i];
      end
    end
  end
endmodule

// File: rtl/usbrx_ep_regs.sv
module usbrx_ep_regs
  import usbrx_pkg::*;
#(
  parameter int              NUM_EP       = 4,
  parameter logic [NUM_EP-1:0] CTRL_EP_MASK = 4'b0001,
  parameter logic [NUM_EP-1:0] ISO_EP_MASK  = 4'b1000,
  parameter logic [NUM_EP-1:0] EN_RST_MASK  = 4'b0001,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usb_rst,
  input  logic [EP_W-1:0]   cpu_ep,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic              cpu_last_rd,
  input  logic [EP_W-1:0]   ev_ep,
  input  logic              ev_out_ack,
  input  logic              ev_setup_tok,
  input  logic              ev_setup_ack,
  input  logic              ev_data_arrive,
  output logic              ev_accept,
  output logic [NUM_EP-1:0] ep_rx_en,
  output logic [NUM_EP-1:0] ep_rx_iso,
  output logic [NUM_EP-1:0] ep_rx_seq
);
  logic [NUM_EP-1:0][REG_W-1:0] cfg_bytes, stat_bytes;
  logic same_ep_collision;

  assign same_ep_collision = cpu_last_rd & ev_data_arrive & (cpu_ep == ev_ep);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic cpu_hit, ev_hit;
    assign cpu_hit = cpu_wr & (cpu_ep == EP_W'(i));
    assign ev_hit  = (ev_ep == EP_W'(i));

    usbrx_ep_slice #(
      .IS_CTRL(CTRL_EP_MASK[i]),
      .ISO_CAP(ISO_EP_MASK[i]),
      .EN_RST (EN_RST_MASK[i])
    ) u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .usb_rst    (usb_rst),
      .wr_cfg_i   (cpu_hit & (cpu_addr == ADDR_CFG)),
      .wr_stat_i  (cpu_hit & (cpu_addr == ADDR_STAT)),
      .wdata_i    (cpu_wdata),
      .out_ack_i  (ev_hit & ev_out_ack),
      .setup_tok_i(ev_hit & ev_setup_tok),
      .setup_ack_i(ev_hit & ev_setup_ack),
      .conflict_i (ev_hit & same_ep_collision),
      .en_o       (ep_rx_en[i]),
      .iso_o      (ep_rx_iso[i]),
      .seq_o      (ep_rx_seq[i]),
      .cfg_byte_o (cfg_bytes[i]),
      .stat_byte_o(stat_bytes[i])
    );
  end

  usbrx_rd_mux #(.NUM_EP(NUM_EP)) u_rd_mux (
    .sel_ep    (cpu_ep),
    .sel_addr  (cpu_addr),
    .cfg_bytes (cfg_bytes),
    .stat_bytes(stat_bytes),
    .rdata     (cpu_rdata)
  );

  assign ev_accept = ep_rx_en[ev_ep];

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n || usb_rst)
    cpu_addr == ADDR_STAT |-> cpu_rdata[ST_UNLOCK] == 1'b0 && cpu_rdata[1:0] == 2'b00);
  assert_iso_only_ep3_R10: assert property (@(posedge clk) disable iff (!rst_n || usb_rst)
    (ep_rx_iso & ~ISO_EP_MASK) == '0);
endmodule

// File: tb/tb_usbrx_ep_regs.sv
module tb_usbrx_ep_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, usb_rst = 1'b0;
  logic [1:0] cpu_ep = '0, cpu_addr = '0, ev_ep = '0;
  logic       cpu_wr = 1'b0, cpu_last_rd = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       ev_out_ack = 1'b0, ev_setup_tok = 1'b0, ev_setup_ack = 1'b0, ev_data_arrive = 1'b0;
  logic       ev_accept;
  logic [3:0] ep_rx_en, ep_rx_iso, ep_rx_seq;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_valid = 1'b0;

  always #4 clk = ~clk;

  usbrx_ep_regs dut (
    .clk(clk), .rst_n(rst_n), .usb_rst(usb_rst), .cpu_ep(cpu_ep), .cpu_addr(cpu_addr),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_last_rd(cpu_last_rd),
    .ev_ep(ev_ep), .ev_out_ack(ev_out_ack), .ev_setup_tok(ev_setup_tok),
    .ev_setup_ack(ev_setup_ack), .ev_data_arrive(ev_data_arrive), .ev_accept(ev_accept),
    .ep_rx_en(ep_rx_en), .ep_rx_iso(ep_rx_iso), .ep_rx_seq(ep_rx_seq));

  // monitor: pops expected read data and compares mid-cycle
  always @(negedge clk) begin
    if (rd_valid && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (cpu_rdata !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, cpu_rdata, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] ep, input logic [1:0] a, input logic [7:0] e, input string t);
    cpu_ep = ep; cpu_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    rd_valid = 1'b1;
    tick();
    rd_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] ep, input logic [1:0] a, input logic [7:0] d);
    cpu_ep = ep; cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    tick();
    cpu_wr = 1'b0;
  endtask

  task automatic ev(input logic [1:0] ep, input logic oack, input logic stok, input logic sack);
    ev_ep = ep; ev_out_ack = oack; ev_setup_tok = stok; ev_setup_ack = sack;
    tick();
    ev_out_ack = 1'b0; ev_setup_tok = 1'b0; ev_setup_ack = 1'b0;
  endtask

  task automatic collide(input logic [1:0] cep, input logic [1:0] eep);
    cpu_ep = cep; ev_ep = eep; cpu_last_rd = 1'b1; ev_data_arrive = 1'b1;
    tick();
    cpu_last_rd = 1'b0; ev_data_arrive = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(0, 0, 8'h01, "R1 ep0 cfg");
    rd(1, 0, 8'h00, "R1 ep1 cfg");
    rd(3, 0, 8'h00, "R1 ep3 cfg");
    rd(0, 1, 8'h00, "R1 ep0 stat");
    chk({4'b0, ep_rx_en}, 8'h01, "R1 ep_rx_en");
    // R10 iso only on endpoint 3
    wr(1, 0, 8'h01); wr(2, 0, 8'h03); wr(3, 0, 8'h03);
    rd(2, 0, 8'h01, "R10 ep2 iso dropped");
    rd(3, 0, 8'h03, "R10 ep3 iso kept");
    chk({4'b0, ep_rx_iso}, 8'h08, "R10 ep_rx_iso");
    // R3 toggle on OUT ack
    ev(1, 1, 0, 0);
    rd(1, 1, 8'h80, "R3 first toggle");
    chk({4'b0, ep_rx_seq}, 8'h02, "R3 ep_rx_seq");
    ev(1, 1, 0, 0);
    rd(1, 1, 8'h00, "R3 second toggle");
    // R4 unlock
    wr(1, 1, 8'h80);
    rd(1, 1, 8'h00, "R4 locked write");
    wr(1, 1, 8'h88);
    rd(1, 1, 8'h80, "R4 unlocked write, bit3 reads 0");
    wr(1, 1, 8'h08);
    rd(1, 1, 8'h00, "R4 unlocked clear");
    // R6 / R7 / R5 setup sequence on endpoint 0
    ev(0, 0, 1, 0);
    rd(0, 1, 8'h20, "R6 start overwrite set");
    wr(0, 1, 8'h00);
    rd(0, 1, 8'h20, "R6 start overwrite read-only");
    ev(0, 0, 0, 1);
    rd(0, 1, 8'hD0, "R7 R5 setup ack");
    wr(0, 1, 8'hC0);
    rd(0, 1, 8'hC0, "R7 end overwrite cleared");
    wr(0, 1, 8'h80);
    rd(0, 1, 8'h80, "R5 setup cleared");
    // R6 non-control endpoint ignores setup events
    ev(1, 0, 1, 0);
    ev(1, 0, 0, 1);
    rd(1, 1, 8'h00, "R6 non-control setup ignored");
    // R8 collision
    collide(2, 2);
    rd(2, 1, 8'h04, "R8 collision set");
    wr(2, 1, 8'h04);
    rd(2, 1, 8'h04, "R8 write 1 keeps");
    wr(2, 1, 8'h00);
    rd(2, 1, 8'h00, "R8 write 0 clears");
    collide(1, 2);
    rd(2, 1, 8'h00, "R8 different endpoints ep2");
    rd(1, 1, 8'h00, "R8 different endpoints ep1");
    // R9 disabled endpoint
    wr(1, 0, 8'h00);
    ev_ep = 2'd1; #1;
    chk({7'b0, ev_accept}, 8'h00, "R9 accept low");
    ev(1, 1, 0, 0);
    rd(1, 1, 8'h00, "R9 out ack ignored");
    ev_ep = 2'd0; #1;
    chk({7'b0, ev_accept}, 8'h01, "R9 accept high ep0");
    // R11 hardware wins
    wr(0, 1, 8'h08);
    rd(0, 1, 8'h00, "R11 prep");
    cpu_ep = 0; cpu_addr = 1; cpu_wdata = 8'h08; cpu_wr = 1'b1;
    ev_ep = 0; ev_setup_ack = 1'b1;
    tick();
    cpu_wr = 1'b0; ev_setup_ack = 1'b0;
    rd(0, 1, 8'hD0, "R11 setup ack beats clear");
    cpu_ep = 3; cpu_addr = 1; cpu_wdata = 8'h08; cpu_wr = 1'b1;
    ev_ep = 3; ev_out_ack = 1'b1;
    tick();
    cpu_wr = 1'b0; ev_out_ack = 1'b0;
    rd(3, 1, 8'h80, "R11 toggle beats unlocked write");
    // R2 unused addresses
    rd(0, 2, 8'h00, "R2 addr2 reads 0");
    wr(0, 3, 8'hFF);
    rd(0, 0, 8'h01, "R2 addr3 write ignored");
    // R1 bus reset
    usb_rst = 1'b1; tick(); usb_rst = 1'b0;
    rd(0, 0, 8'h01, "R1 usb reset ep0 cfg");
    rd(3, 0, 8'h00, "R1 usb reset ep3 cfg");
    rd(0, 1, 8'h00, "R1 usb reset ep0 stat");
    rd(3, 1, 8'h00, "R1 usb reset ep3 stat");
    chk({4'b0, ep_rx_en}, 8'h01, "R1 usb reset ep_rx_en");
    tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule